// File: doc/BRIEF.md
# Paired-Byte Access Bridge for Wide Timer Registers

This block lets a CPU with an 8-bit data bus reach four 16-bit peripheral registers: a counter, two compare values and a capture value. Each register occupies two byte addresses, one for its upper half and one for its lower half. A single 8-bit holding latch is shared by all four registers. It lets a two-step byte sequence act on the register as one indivisible 16-bit event.

Writing an upper byte only parks the byte in the holding latch. The following lower-byte write then commits both halves in one clock edge. Reading a lower byte returns that half and, on the same edge, freezes the matching upper half into the holding latch, so a later upper-byte read returns a value coherent with the lower one. The compare registers are the exception on reads: their upper byte is read straight from the register. The counter and capture registers also accept a full 16-bit load from the hardware side, which is driven by timer logic outside this block.

Top module: `wide_reg_bridge`

## Requirements
- R1: Byte address bit 0 selects the half (1 = upper byte, 0 = lower byte) and address bits 2:1 select the register (0 = counter, 1 = compare A, 2 = compare B, 3 = capture); each register's full value is visible on its own 16-bit output.
- R2: One 8-bit holding latch serves all four registers; an access to any register can replace what an access to another one left there.
- R3: A CPU write to an upper-byte address loads the holding latch with the written byte and leaves every 16-bit register unchanged.
- R4: A CPU write to a lower-byte address sets the selected register to {holding latch, written byte} on that clock edge.
- R5: A CPU read of a lower-byte address (read enable high, write enable low) returns the lower half of the selected register on rdata_o and copies that register's upper half into the holding latch on the same edge.
- R6: A CPU read of the upper-byte address of the counter or capture register returns the holding latch contents, whatever register last loaded it.
- R7: A CPU read of a compare register's upper-byte address returns that register's upper half directly and leaves the holding latch unchanged.
- R8: An access to another register between the two halves of a 16-bit access corrupts the pending access: a write then commits the other byte as its upper half, and a read then returns the other register's upper half.
- R9: The counter and capture registers load their hardware-side value on any edge where its load strobe is high; a CPU lower-byte write to the same register on the same edge takes priority.
- R10: Reset (rst_ni low) clears all four registers and the holding latch to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | CPU byte write strobe |
| rd_en_i | input | 1 | CPU byte read strobe |
| addr_i | input | 3 | Byte address: {register index, upper-half flag} |
| wdata_i | input | 8 | CPU write byte |
| rdata_o | output | 8 | CPU read byte for the addressed location (combinational) |
| cnt_hw_we_i | input | 1 | Hardware load strobe for the counter |
| cnt_hw_d_i | input | 16 | Hardware load value for the counter |
| cap_hw_we_i | input | 1 | Hardware load strobe for the capture register |
| cap_hw_d_i | input | 16 | Hardware load value for the capture register |
| cnt_o | output | 16 | Counter register value |
| cmp_a_o | output | 16 | Compare A register value |
| cmp_b_o | output | 16 | Compare B register value |
| cap_o | output | 16 | Capture register value |

## Verification
The hardest situations to reach are the ones where the shared latch carries the wrong byte into an access: an upper-byte write to one register followed by a lower-byte write to another, and a lower-byte read of one register followed by an upper-byte read of another. The stimulus builds both on purpose by interleaving accesses to the counter, compare and capture registers. It then checks that the committed register and the returned byte carry the intruding value. The collision between a hardware load and a CPU commit on the same edge is forced by raising the load strobe in the same cycle as a lower-byte write.

// File: rtl/wrb_pkg.sv
package wrb_pkg;
  localparam int BYTE_W   = 8;
  localparam int NUM_REGS = 4;
  localparam int IDX_W    = $clog2(NUM_REGS);
  localparam int ADDR_W   = IDX_W + 1;

  typedef enum logic [IDX_W-1:0] {
    REG_CNT   = 2'd0,
    REG_CMP_A = 2'd1,
    REG_CMP_B = 2'd2,
    REG_CAP   = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/wrb_decode.sv
module wrb_decode #(
  parameter int NUM_REGS = 4,
  parameter int IDX_W    = $clog2(NUM_REGS),
  parameter int ADDR_W   = IDX_W + 1
) (
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              hi_o,
  output logic              wr_hi_o,
  output logic [NUM_REGS-1:0] wr_lo_o,
  output logic [NUM_REGS-1:0] rd_lo_o
);
  assign idx_o   = addr_i[ADDR_W-1:1];
  assign hi_o    = addr_i[0];
  assign wr_hi_o = wr_en_i & hi_o;

  always_comb begin
    wr_lo_o = '0;
    rd_lo_o = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (idx_o == IDX_W'(i)) begin
        wr_lo_o[i] = wr_en_i & ~hi_o;
        rd_lo_o[i] = rd_en_i & ~wr_en_i & ~hi_o;
      end
    end
  end

  // R1
  always_comb begin
    decode_onehot_chk: assert ($onehot0(wr_lo_o | rd_lo_o));
  end
endmodule

// File: rtl/wrb_hold_latch.sv
module wrb_hold_latch #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] load_d_i,
  input  logic              snap_i,
  input  logic [BYTE_W-1:0] snap_d_i,
  output logic [BYTE_W-1:0] hold_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hold_o <= '0;
    else if (load_i) hold_o <= load_d_i;
    else if (snap_i) hold_o <= snap_d_i;
  end

  // R3
  hold_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> hold_o == $past(load_d_i));

  // R5
  hold_snap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snap_i && !load_i) |=> hold_o == $past(snap_d_i));

  // R2
  hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!snap_i && !load_i) |=> $stable(hold_o));
endmodule

// File: rtl/wrb_reg_slot.sv
module wrb_reg_slot #(
  parameter int BYTE_W = 8,
  parameter bit HAS_HW = 1'b0,
  parameter int REG_W  = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_we_i,
  input  logic [BYTE_W-1:0] cpu_hi_i,
  input  logic [BYTE_W-1:0] cpu_lo_i,
  input  logic              hw_we_i,
  input  logic [REG_W-1:0]  hw_d_i,
  output logic [REG_W-1:0]  q_o
);
  logic hw_take;

  if (HAS_HW) begin : g_hw
    assign hw_take = hw_we_i;
  end else begin : g_no_hw
    logic unused_hw;
    assign unused_hw = hw_we_i ^ (^hw_d_i);
    assign hw_take   = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q_o <= '0;
    else if (cpu_we_i) q_o <= {cpu_hi_i, cpu_lo_i};
    else if (hw_take)  q_o <= hw_d_i;
  end

  // R4 / R9 CPU commit wins over a simultaneous hardware load
  cpu_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_we_i |=> q_o == {$past(cpu_hi_i), $past(cpu_lo_i)});

  // R3
  slot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_we_i && !hw_take) |=> $stable(q_o));
endmodule

// File: rtl/wide_reg_bridge.sv
module wide_reg_bridge
  import wrb_pkg::*;
#(
  parameter int                BYTE_W      = wrb_pkg::BYTE_W,
  parameter logic [NUM_REGS-1:0] HW_MASK   = 4'b1001,
  parameter logic [NUM_REGS-1:0] DIRECT_HI = 4'b0110,
  parameter int                REG_W       = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic              cnt_hw_we_i,
  input  logic [REG_W-1:0]  cnt_hw_d_i,
  input  logic              cap_hw_we_i,
  input  logic [REG_W-1:0]  cap_hw_d_i,
  output logic [REG_W-1:0]  cnt_o,
  output logic [REG_W-1:0]  cmp_a_o,
  output logic [REG_W-1:0]  cmp_b_o,
  output logic [REG_W-1:0]  cap_o
);
  logic [IDX_W-1:0]    idx;
  logic                hi_sel;
  logic                wr_hi;
  logic [NUM_REGS-1:0] wr_lo;
  logic [NUM_REGS-1:0] rd_lo;
  logic [BYTE_W-1:0]   hold;
  logic [REG_W-1:0]    regs  [NUM_REGS];
  logic [REG_W-1:0]    hw_d  [NUM_REGS];
  logic [NUM_REGS-1:0] hw_we;
  logic [BYTE_W-1:0]   snap_d;

  wrb_decode #(.NUM_REGS(NUM_REGS)) u_decode (
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .idx_o   (idx),
    .hi_o    (hi_sel),
    .wr_hi_o (wr_hi),
    .wr_lo_o (wr_lo),
    .rd_lo_o (rd_lo)
  );

  assign snap_d = regs[idx][REG_W-1:BYTE_W];

  wrb_hold_latch #(.BYTE_W(BYTE_W)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (wr_hi),
    .load_d_i (wdata_i),
    .snap_i   (|rd_lo),
    .snap_d_i (snap_d),
    .hold_o   (hold)
  );

  always_comb begin
    hw_we          = '0;
    hw_we[REG_CNT] = cnt_hw_we_i;
    hw_we[REG_CAP] = cap_hw_we_i;
    for (int i = 0; i < NUM_REGS; i++) hw_d[i] = '0;
    hw_d[REG_CNT]  = cnt_hw_d_i;
    hw_d[REG_CAP]  = cap_hw_d_i;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
    wrb_reg_slot #(.BYTE_W(BYTE_W), .HAS_HW(HW_MASK[g])) u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cpu_we_i (wr_lo[g]),
      .cpu_hi_i (hold),
      .cpu_lo_i (wdata_i),
      .hw_we_i  (hw_we[g]),
      .hw_d_i   (hw_d[g]),
      .q_o      (regs[g])
    );
  end

  always_comb begin
    if (!hi_sel)             rdata_o = regs[idx][BYTE_W-1:0];
    else if (DIRECT_HI[idx]) rdata_o = regs[idx][REG_W-1:BYTE_W];
    else                     rdata_o = hold;
  end

  assign cnt_o   = regs[REG_CNT];
  assign cmp_a_o = regs[REG_CMP_A];
  assign cmp_b_o = regs[REG_CMP_B];
  assign cap_o   = regs[REG_CAP];

  // R7
  direct_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !wr_en_i && hi_sel && DIRECT_HI[idx]) |=> $stable(hold));

  // R3
  hi_wr_cmp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && hi_sel) |=> ($stable(cmp_a_o) && $stable(cmp_b_o)));

  // R9
  hw_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_hw_we_i && !(wr_en_i && !hi_sel && idx == REG_CAP)) |=> cap_o == $past(cap_hw_d_i));
endmodule

// File: tb/wide_reg_bridge_tb_top.sv
`timescale 1ns/1ps
module wide_reg_bridge_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic        cnt_hw_we_i = 1'b0;
  logic [15:0] cnt_hw_d_i = '0;
  logic        cap_hw_we_i = 1'b0;
  logic [15:0] cap_hw_d_i = '0;
  logic [15:0] cnt_o, cmp_a_o, cmp_b_o, cap_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  wide_reg_bridge dut_i (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i, .rdata_o,
    .cnt_hw_we_i, .cnt_hw_d_i, .cap_hw_we_i, .cap_hw_d_i,
    .cnt_o, .cmp_a_o, .cmp_b_o, .cap_o
  );

  // {is_read, addr[2:0], data}: data is write byte or expected read byte
  localparam int NVEC = 20;
  localparam logic [11:0] VEC [NVEC] = '{
    12'h112, 12'h034, 12'h834, 12'h912, 12'h3AB,
    12'hB00, 12'h2CD, 12'hBAB, 12'hACD, 12'h55A,
    12'h4A5, 12'h834, 12'hD5A, 12'h912, 12'h777,
    12'h666, 12'hE66, 12'hF77, 12'h199, 12'hF99
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic cpu_rd(input logic [2:0] a, output logic [7:0] r);
    @(negedge clk_i);
    rd_en_i = 1'b1; addr_i = a;
    #1 r = rdata_o;
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk("R10 cnt", cnt_o, 16'h0);
    chk("R10 cmp_a", cmp_a_o, 16'h0);
    chk("R10 cmp_b", cmp_b_o, 16'h0);
    chk("R10 cap", cap_o, 16'h0);
    rst_ni = 1'b1;
    cpu_rd(3'd7, r);
    chk("R10 hold latch", {8'h0, r}, 16'h0);

    // vector table: R1 R3 R4 R5 R6 R7
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][11]) begin
        cpu_rd(VEC[i][10:8], r);
        chk($sformatf("R5/R6/R7 vec %0d", i), {8'h0, r}, {8'h0, VEC[i][7:0]});
      end else begin
        cpu_wr(VEC[i][10:8], VEC[i][7:0]);
      end
    end
    chk("R1 R4 cnt", cnt_o, 16'h1234);
    chk("R1 R4 cmp_a", cmp_a_o, 16'hABCD);
    chk("R1 R4 cmp_b", cmp_b_o, 16'h5AA5);
    chk("R1 R4 cap", cap_o, 16'h7766);

    // R3 high write alone changes no register
    cpu_wr(3'd5, 8'hEE);
    chk("R3 cmp_b untouched", cmp_b_o, 16'h5AA5);
    chk("R3 cnt untouched", cnt_o, 16'h1234);

    // R8 R2 interleaved write corrupts upper byte
    cpu_wr(3'd1, 8'h11);
    cpu_wr(3'd3, 8'h22);
    cpu_wr(3'd0, 8'h33);
    chk("R8 write corrupted", cnt_o, 16'h2233);
    chk("R8 cmp_a unchanged", cmp_a_o, 16'hABCD);

    // R8 interleaved read corrupts upper byte
    cpu_rd(3'd0, r);
    chk("R5 cnt lo", {8'h0, r}, 16'h0033);
    cpu_rd(3'd6, r);
    chk("R5 cap lo", {8'h0, r}, 16'h0066);
    cpu_rd(3'd1, r);
    chk("R8 read corrupted", {8'h0, r}, 16'h0077);

    // R9 hardware load alone
    @(negedge clk_i);
    cap_hw_we_i = 1'b1; cap_hw_d_i = 16'h1357;
    @(negedge clk_i);
    cap_hw_we_i = 1'b0;
    chk("R9 cap hw load", cap_o, 16'h1357);

    // R9 CPU commit beats hardware load
    cpu_wr(3'd1, 8'h55);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = 3'd0; wdata_i = 8'h44;
    cnt_hw_we_i = 1'b1; cnt_hw_d_i = 16'hBEEF;
    @(negedge clk_i);
    wr_en_i = 1'b0; cnt_hw_we_i = 1'b0;
    chk("R9 cpu priority", cnt_o, 16'h5544);

    // R9 hardware load alongside an upper-byte write
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = 3'd1; wdata_i = 8'h66;
    cnt_hw_we_i = 1'b1; cnt_hw_d_i = 16'h0F0F;
    @(negedge clk_i);
    wr_en_i = 1'b0; cnt_hw_we_i = 1'b0;
    chk("R9 hw with hi write", cnt_o, 16'h0F0F);
    cpu_wr(3'd0, 8'h01);
    chk("R4 commit after hw", cnt_o, 16'h6601);

    // R10 reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R10 cnt after reset", cnt_o, 16'h0);
    chk("R10 cmp_a after reset", cmp_a_o, 16'h0);
    rst_ni = 1'b1;
    cpu_rd(3'd1, r);
    chk("R10 hold after reset", {8'h0, r}, 16'h0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule